// File: doc/BRIEF.md
# Multi-Source Reset Sequencing Controller

This block collects four kinds of reset request and turns them into a timed release of per-domain reset lines. The four kinds are a power-on pin, a warm-reset pin, a system request (from a debug or serial-link source) and a CPU-local request (from a watchdog). Each kind resets its own set of domains. The power-on sequence additionally captures the configuration straps. It then lets the secondary PLL out of reset and waits for that PLL to report lock. Every sequence ends with a pause of the system clock enables, after which the domains are released.

The reset-status output is active low. It stays low from the moment a sequence starts until every domain has been released. If the PLL does not lock within a set number of cycles, an error flag rises and the block stays in reset until the next power-on.

The power-on pin drives the asynchronous reset of the whole block through a two-stage synchronizer. The warm pin is synchronized in the same way. The system and CPU-local requests are synchronous pulses or levels in the reference-clock domain.

Top module: `rstseq_ctrl`

## Requirements
- R1: While `por_n` is low, every `dom_rst_n` bit, `status_n`, every `clk_en` bit, `strap_stb` and `lock_err` are low, with no clock edge needed. Release is synchronous, through two register stages.
- R2: `strap_q` loads `strap_in` on the first clock edge after the internal release, which is the third edge after `por_n` rises. `strap_stb` is high for exactly that one cycle. Warm, system and CPU-local resets never pulse `strap_stb` and never change `strap_q`.
- R3: The domain bit order is: 0 CPU, 1 peripherals, 2 memory, 3 secondary PLL, 4 always-on interfaces (frame-sync and antenna link), 5 test/debug. Power-on resets bits 0 to 5. Warm resets bits 0 to 2. System resets bits 0 to 1. CPU-local resets bit 0 only. Bits outside the class mask stay high.
- R4: The priority order is warm, then system, then CPU-local. Simultaneous requests start the highest of them. A request of equal or higher priority arriving during a sequence restarts the hold phase with its own class. A lower-priority request arriving during a sequence is dropped and does not lengthen it.
- R5: In a power-on sequence, `dom_rst_n[3]` rises HOLD_CYC-1 cycles after the `strap_stb` cycle while the other domains stay in reset. `status_n` then waits for lock. It rises PAUSE_CYC+3 cycles after `pll_lock` goes high.
- R6: If lock is not seen within LOCK_TMO cycles of the PLL release, `lock_err` rises and stays high. `status_n` stays low. Warm, system and CPU-local requests, and a late lock, change nothing until `por_n` is pulsed.
- R7: For warm, system and CPU-local sequences, `clk_en` stays high during the hold phase, then is low for exactly PAUSE_CYC cycles before the release. In a power-on sequence, `clk_en` stays low until the release.
- R8: At release, all `dom_rst_n` bits, `status_n` and `clk_en` rise together. With lock already present, a power-on sequence releases HOLD_CYC+PAUSE_CYC cycles after the `strap_stb` cycle. A system or CPU-local request releases HOLD_CYC+PAUSE_CYC+1 edges after it is driven.
- R9: `periph_clr` is high throughout a power-on sequence and low for all other classes and in normal running.
- R10: While `warm_n` is held low, the hold phase does not advance. The release comes 2+HOLD_CYC+PAUSE_CYC edges after `warm_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Power-on reset pin, active low, asynchronous |
| warm_n | input | 1 | Warm reset pin, active low, asynchronous |
| sys_req | input | 1 | System reset request, synchronous, active high |
| cpu_req | input | 1 | CPU-local reset request, synchronous, active high |
| pll_lock | input | 1 | Secondary PLL lock indication |
| strap_in | input | STRAP_W | Configuration strap inputs |
| dom_rst_n | output | 6 | Per-domain reset, active low |
| status_n | output | 1 | Reset status, low while any sequence runs |
| clk_en | output | NCLK | System clock enables of the clock controllers |
| strap_q | output | STRAP_W | Captured strap values |
| strap_stb | output | 1 | One-cycle strobe when straps are captured |
| periph_clr | output | 1 | Clear for power-managed peripheral enables |
| lock_err | output | 1 | PLL lock timeout flag |

## Verification
The outputs are Moore decodes of the sequencer state, so each one changes on the edge that moves the state. The warm pin adds two synchronizer edges, and lock adds two more edges before the sequence advances. The bench drives every stimulus on a falling edge and counts falling edges until the watched output changes. It compares that count with a figure computed from HOLD_CYC, PAUSE_CYC and LOCK_TMO, for example HOLD_CYC+PAUSE_CYC+1 for a one-cycle system pulse, 2+HOLD_CYC+PAUSE_CYC after warm release, and PAUSE_CYC+3 after lock. Mask checks are made one edge after a request, and the asynchronous power-on check is made before any edge occurs.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  localparam int NDOM   = 6;
  localparam int D_CPU  = 0;
  localparam int D_PERI = 1;
  localparam int D_MEM  = 2;
  localparam int D_PLL  = 3;
  localparam int D_IFC  = 4;
  localparam int D_TEST = 5;

  // lower code = higher priority
  typedef enum logic [1:0] {
    C_POR  = 2'd0,
    C_WARM = 2'd1,
    C_SYS  = 2'd2,
    C_CPU  = 2'd3
  } rcls_e;

  typedef enum logic [2:0] {
    S_HOLD  = 3'd0,
    S_LOCKW = 3'd1,
    S_PAUSE = 3'd2,
    S_RUN   = 3'd3,
    S_ERR   = 3'd4
  } seq_e;

  function automatic logic [NDOM-1:0] cls_mask(input rcls_e c);
    logic [NDOM-1:0] m;
    m = '0;
    case (c)
      C_POR:   m = '1;
      C_WARM:  begin m[D_CPU] = 1'b1; m[D_PERI] = 1'b1; m[D_MEM] = 1'b1; end
      C_SYS:   begin m[D_CPU] = 1'b1; m[D_PERI] = 1'b1; end
      default: m[D_CPU] = 1'b1;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic s1_q;
  logic s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

endmodule

// File: rtl/rstseq_arb.sv
module rstseq_arb
  import rstseq_pkg::*;
(
  input  logic  warm_req,
  input  logic  sys_req,
  input  logic  cpu_req,
  input  logic  busy,
  input  rcls_e cur_cls,
  output logic  hit,
  output rcls_e new_cls
);

  logic pend;

  always_comb begin
    pend    = 1'b1;
    new_cls = C_CPU;
    if (warm_req)     new_cls = C_WARM;
    else if (sys_req) new_cls = C_SYS;
    else if (cpu_req) new_cls = C_CPU;
    else              pend    = 1'b0;
  end

  // idle: any request starts; busy: only equal or higher priority restarts
  assign hit = pend && (!busy || (new_cls <= cur_cls));

endmodule

// File: rtl/rstseq_dommap.sv
module rstseq_dommap
  import rstseq_pkg::*;
#(
  parameter int NCLK = 2
) (
  input  seq_e              state,
  input  rcls_e             cls,
  output logic [NDOM-1:0]   dom_rst_n,
  output logic              status_n,
  output logic [NCLK-1:0]   clk_en,
  output logic              periph_clr,
  output logic              lock_err
);

  logic            running;
  logic            pll_free;
  logic            clk_on;
  logic [NDOM-1:0] in_rst;

  assign running  = (state == S_RUN);
  assign pll_free = (state == S_LOCKW) || (state == S_PAUSE) || (state == S_ERR);

  always_comb begin
    in_rst = '0;
    if (!running) begin
      in_rst = cls_mask(cls);
      if (pll_free) in_rst[D_PLL] = 1'b0;
    end
  end

  assign dom_rst_n  = ~in_rst;
  assign status_n   = running;
  assign clk_on     = running || ((cls != C_POR) && (state == S_HOLD));
  assign periph_clr = (cls == C_POR) && !running;
  assign lock_err   = (state == S_ERR);

  for (genvar g = 0; g < NCLK; g++) begin : g_clk_en
    assign clk_en[g] = clk_on;
  end

endmodule

// File: rtl/rstseq_ctrl.sv
module rstseq_ctrl
  import rstseq_pkg::*;
#(
  parameter int STRAP_W   = 8,
  parameter int NCLK      = 2,
  parameter int HOLD_CYC  = 16,
  parameter int PAUSE_CYC = 10,
  parameter int LOCK_TMO  = 4096
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               warm_n,
  input  logic               sys_req,
  input  logic               cpu_req,
  input  logic               pll_lock,
  input  logic [STRAP_W-1:0] strap_in,
  output logic [NDOM-1:0]    dom_rst_n,
  output logic               status_n,
  output logic [NCLK-1:0]    clk_en,
  output logic [STRAP_W-1:0] strap_q,
  output logic               strap_stb,
  output logic               periph_clr,
  output logic               lock_err
);

  localparam int CNT_MAX_A = (HOLD_CYC > PAUSE_CYC) ? HOLD_CYC : PAUSE_CYC;
  localparam int CNT_MAX   = (CNT_MAX_A > LOCK_TMO) ? CNT_MAX_A : LOCK_TMO;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] PAUSE_LAST = CNT_W'(PAUSE_CYC - 1);
  localparam logic [CNT_W-1:0] TMO_LAST   = CNT_W'(LOCK_TMO - 1);

  logic rst_n_s;
  logic warm_s;
  logic lock_s;

  rstseq_sync u_por_sync  (.clk(clk), .arst_n(por_n),   .d(1'b1),     .q(rst_n_s));
  rstseq_sync u_warm_sync (.clk(clk), .arst_n(warm_n),  .d(1'b1),     .q(warm_s));
  rstseq_sync u_lock_sync (.clk(clk), .arst_n(rst_n_s), .d(pll_lock), .q(lock_s));

  seq_e             state_q, state_n;
  rcls_e            cls_q,   cls_n;
  logic [CNT_W-1:0] cnt_q,   cnt_n;
  logic             first_q;
  logic             stb_q;
  logic [STRAP_W-1:0] strap_r;

  logic  arb_hit;
  rcls_e arb_cls;

  rstseq_arb u_arb (
    .warm_req (~warm_s),
    .sys_req  (sys_req),
    .cpu_req  (cpu_req),
    .busy     (state_q != S_RUN),
    .cur_cls  (cls_q),
    .hit      (arb_hit),
    .new_cls  (arb_cls)
  );

  always_comb begin
    state_n = state_q;
    cls_n   = cls_q;
    cnt_n   = cnt_q;
    if (arb_hit) begin
      state_n = S_HOLD;
      cls_n   = arb_cls;
      cnt_n   = '0;
    end else begin
      case (state_q)
        S_HOLD: begin
          if (cnt_q == HOLD_LAST) begin
            cnt_n   = '0;
            state_n = (cls_q == C_POR) ? S_LOCKW : S_PAUSE;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        S_LOCKW: begin
          if (lock_s) begin
            cnt_n   = '0;
            state_n = S_PAUSE;
          end else if (cnt_q == TMO_LAST) begin
            cnt_n   = '0;
            state_n = S_ERR;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        S_PAUSE: begin
          if (cnt_q == PAUSE_LAST) begin
            cnt_n   = '0;
            state_n = S_RUN;
          end else begin
            cnt_n = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= S_HOLD;
      cls_q   <= C_POR;
      cnt_q   <= '0;
      first_q <= 1'b1;
      stb_q   <= 1'b0;
      strap_r <= '0;
    end else begin
      state_q <= state_n;
      cls_q   <= cls_n;
      cnt_q   <= cnt_n;
      first_q <= 1'b0;
      stb_q   <= first_q;
      if (first_q) strap_r <= strap_in;
    end
  end

  assign strap_q   = strap_r;
  assign strap_stb = stb_q;

  rstseq_dommap #(.NCLK(NCLK)) u_map (
    .state      (state_q),
    .cls        (cls_q),
    .dom_rst_n  (dom_rst_n),
    .status_n   (status_n),
    .clk_en     (clk_en),
    .periph_clr (periph_clr),
    .lock_err   (lock_err)
  );

endmodule

// File: rtl/rstseq_ctrl_chk.sv
module rstseq_ctrl_chk
  import rstseq_pkg::*;
#(
  parameter int NCLK = 2
) (
  input logic            clk,
  input logic            por_n,
  input logic            status_n,
  input logic            lock_err,
  input logic            strap_stb,
  input logic [NDOM-1:0] dom_rst_n,
  input logic [NCLK-1:0] clk_en
);

  // R3: the test domain, once out of reset, is never reset again without power-on
  a_r3_test_kept: assert property (@(posedge clk) disable iff (!por_n)
    dom_rst_n[D_TEST] |=> dom_rst_n[D_TEST]);

  // R2: strap strobe lasts one cycle
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!por_n)
    strap_stb |=> !strap_stb);

  // R6: lock error is sticky and keeps status asserted
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!por_n)
    lock_err |=> lock_err);
  a_r6_err_no_status: assert property (@(posedge clk) disable iff (!por_n)
    lock_err |-> !status_n);

  // R7: release always follows a cycle with clocks paused
  a_r7_pause_before_release: assert property (@(posedge clk) disable iff (!por_n)
    $rose(status_n) |-> $past(~|clk_en));

  // R8: running implies all domains released and clocks on
  a_r8_release_all: assert property (@(posedge clk) disable iff (!por_n)
    status_n |-> ((&clk_en) && (&dom_rst_n)));

endmodule

bind rstseq_ctrl rstseq_ctrl_chk #(.NCLK(NCLK)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .status_n  (status_n),
  .lock_err  (lock_err),
  .strap_stb (strap_stb),
  .dom_rst_n (dom_rst_n),
  .clk_en    (clk_en)
);

// File: tb/rstseq_ctrl_bench.sv
`timescale 1ns/1ps
module rstseq_ctrl_bench;

  localparam int STRAP_W = 8;
  localparam int NCLK    = 2;
  localparam int HOLD    = 4;
  localparam int PAUSE   = 10;
  localparam int TMO     = 20;

  logic               clk = 1'b0;
  logic               por_n, warm_n, sys_req, cpu_req, pll_lock;
  logic [STRAP_W-1:0] strap_in;
  logic [5:0]         dom_rst_n;
  logic               status_n;
  logic [NCLK-1:0]    clk_en;
  logic [STRAP_W-1:0] strap_q;
  logic               strap_stb, periph_clr, lock_err;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  rstseq_ctrl #(
    .STRAP_W(STRAP_W), .NCLK(NCLK), .HOLD_CYC(HOLD), .PAUSE_CYC(PAUSE), .LOCK_TMO(TMO)
  ) u_rstseq_ctrl (
    .clk(clk), .por_n(por_n), .warm_n(warm_n), .sys_req(sys_req), .cpu_req(cpu_req),
    .pll_lock(pll_lock), .strap_in(strap_in), .dom_rst_n(dom_rst_n), .status_n(status_n),
    .clk_en(clk_en), .strap_q(strap_q), .strap_stb(strap_stb), .periph_clr(periph_clr),
    .lock_err(lock_err)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // counts edges until status_n is high, plus clock-off cycles and strobes seen
  task automatic run_to_status(output int n, output int low, output int stb);
    n = 0; low = 0; stb = 0;
    do begin
      tick();
      n++;
      if (clk_en == '0) low++;
      if (strap_stb) stb++;
    end while (!status_n && n < 300);
  endtask

  task automatic wait_strap(output int k);
    k = 0;
    do begin tick(); k++; end while (!strap_stb && k < 20);
  endtask

  task automatic wait_pll(output int k);
    k = 0;
    do begin tick(); k++; end while (!dom_rst_n[3] && k < 50);
  endtask

  // one-cycle request; checks mask after first edge and release timing
  task automatic req_seq(input logic s, input logic c, input logic [5:0] exp_dom, input string rq);
    int n, low, stb;
    sys_req = s; cpu_req = c;
    tick();
    chk(dom_rst_n == exp_dom, rq, dom_rst_n, exp_dom);
    chk(clk_en == '1, "R7 clocks on in hold", clk_en, 3);
    sys_req = 1'b0; cpu_req = 1'b0;
    run_to_status(n, low, stb);
    chk(n + 1 == HOLD + PAUSE + 1, "R8 pulse release edges", n + 1, HOLD + PAUSE + 1);
    chk(low == PAUSE, "R7 pause length", low, PAUSE);
    chk(stb == 0, "R2 no strobe", stb, 0);
    chk(dom_rst_n == 6'h3F, "R8 all released", dom_rst_n, 63);
  endtask

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int k, n, low, stb;
    por_n = 1'b0; warm_n = 1'b1; sys_req = 1'b0; cpu_req = 1'b0;
    pll_lock = 1'b1; strap_in = 8'hA5;
    tick(); tick(); tick();
    // R1 reset state
    chk(dom_rst_n == 6'h00, "R1 domains in reset", dom_rst_n, 0);
    chk(status_n == 1'b0, "R1 status", status_n, 0);
    chk(clk_en == '0, "R1 clocks", clk_en, 0);
    chk(!strap_stb && !lock_err, "R1 strobe/err", {strap_stb, lock_err}, 0);

    // power-on release with lock present
    por_n = 1'b1;
    wait_strap(k);
    chk(k == 3, "R2 strobe edge", k, 3);
    chk(strap_q == 8'hA5, "R2 strap capture", strap_q, 8'hA5);
    chk(periph_clr == 1'b1, "R9 clear in power-on", periph_clr, 1);
    strap_in = 8'h5A;
    run_to_status(n, low, stb);
    chk(n == HOLD + PAUSE, "R8 power-on release", n, HOLD + PAUSE);
    chk(low == n - 1, "R7 clocks off until release", low, n - 1);
    chk(stb == 0, "R2 single strobe", stb, 0);
    chk(periph_clr == 1'b0, "R9 clear dropped", periph_clr, 0);

    // warm reset
    warm_n = 1'b0;
    tick();
    chk(dom_rst_n == 6'b111000, "R3 warm mask", dom_rst_n, 6'b111000);
    chk(periph_clr == 1'b0, "R9 no clear on warm", periph_clr, 0);
    repeat (6) tick();
    chk(dom_rst_n == 6'b111000 && clk_en == '1 && !status_n, "R10 held while low", dom_rst_n, 6'b111000);
    warm_n = 1'b1;
    run_to_status(n, low, stb);
    chk(n == 2 + HOLD + PAUSE, "R10 warm release", n, 2 + HOLD + PAUSE);
    chk(low == PAUSE, "R7 warm pause", low, PAUSE);
    chk(stb == 0 && strap_q == 8'hA5, "R2 straps kept on warm", strap_q, 8'hA5);

    // system and CPU-local
    req_seq(1'b1, 1'b0, 6'b111100, "R3 system mask");
    chk(strap_q == 8'hA5, "R2 straps kept on system", strap_q, 8'hA5);
    req_seq(1'b0, 1'b1, 6'b111110, "R3 cpu mask");
    req_seq(1'b1, 1'b1, 6'b111100, "R4 simultaneous");

    // restart by higher priority
    cpu_req = 1'b1; tick(); cpu_req = 1'b0;
    chk(dom_rst_n == 6'b111110, "R4 cpu first", dom_rst_n, 6'b111110);
    tick(); tick();
    sys_req = 1'b1; tick(); sys_req = 1'b0;
    chk(dom_rst_n == 6'b111100, "R4 restart by system", dom_rst_n, 6'b111100);
    run_to_status(n, low, stb);
    chk(n == HOLD + PAUSE, "R4 restart timing", n, HOLD + PAUSE);

    // lower priority dropped
    sys_req = 1'b1; tick(); sys_req = 1'b0;
    tick();
    cpu_req = 1'b1; tick(); cpu_req = 1'b0;
    chk(dom_rst_n == 6'b111100, "R4 drop keeps mask", dom_rst_n, 6'b111100);
    run_to_status(n, low, stb);
    chk(n + 3 == HOLD + PAUSE + 1, "R4 drop no extension", n + 3, HOLD + PAUSE + 1);

    // warm restarts a system sequence
    sys_req = 1'b1; tick(); sys_req = 1'b0;
    tick();
    warm_n = 1'b0; tick();
    chk(dom_rst_n == 6'b111000, "R4 warm over system", dom_rst_n, 6'b111000);
    warm_n = 1'b1;
    run_to_status(n, low, stb);
    chk(n == 2 + HOLD + PAUSE, "R4 warm restart timing", n, 2 + HOLD + PAUSE);

    // R1 asynchronous assertion, then lock wait
    por_n = 1'b0;
    #1;
    chk(dom_rst_n == 6'h00 && !status_n && clk_en == '0, "R1 async assert", dom_rst_n, 0);
    tick();
    pll_lock = 1'b0; strap_in = 8'h3C;
    tick();
    por_n = 1'b1;
    wait_strap(k);
    chk(strap_q == 8'h3C, "R2 new straps", strap_q, 8'h3C);
    wait_pll(k);
    chk(k == HOLD - 1, "R5 pll release", k, HOLD - 1);
    chk(dom_rst_n == 6'b001000, "R5 only pll released", dom_rst_n, 6'b001000);
    repeat (5) tick();
    chk(!status_n && clk_en == '0, "R5 waits for lock", status_n, 0);
    pll_lock = 1'b1;
    run_to_status(n, low, stb);
    chk(n == PAUSE + 3, "R5 release after lock", n, PAUSE + 3);

    // lock timeout
    por_n = 1'b0; tick(); pll_lock = 1'b0; tick(); por_n = 1'b1;
    wait_strap(k);
    wait_pll(k);
    k = 0;
    do begin tick(); k++; end while (!lock_err && k < 100);
    chk(k == TMO, "R6 timeout cycles", k, TMO);
    chk(!status_n && dom_rst_n == 6'b001000, "R6 held in reset", dom_rst_n, 6'b001000);
    warm_n = 1'b0; tick(); tick(); warm_n = 1'b1;
    sys_req = 1'b1; tick(); sys_req = 1'b0;
    repeat (5) tick();
    pll_lock = 1'b1;
    repeat (5) tick();
    chk(lock_err && !status_n && dom_rst_n == 6'b001000, "R6 requests ignored", dom_rst_n, 6'b001000);

    // recovery by power-on
    por_n = 1'b0; tick(); tick(); por_n = 1'b1;
    wait_strap(k);
    run_to_status(n, low, stb);
    chk(n == HOLD + PAUSE && !lock_err, "R6 cleared by power-on", n, HOLD + PAUSE);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule